// File: doc/BRIEF.md
# Flag-Tracking Byte ALU

The block is the datapath execute stage of a small 8-bit processor. One operation is accepted per handshake. The operation carries a 16-bit operand A (a register pair, of which only the low byte is used by byte operations), an 8-bit operand B (a register value or an immediate), a 3-bit bit index and an operation code. The block computes the result and whether it is to be written back. For branch-test operations it also computes a taken bit. It updates its own 8-bit status register in the same clock edge.

Every operation changes only the flags that belong to it, and all other flags keep their value. The signed-test flag is rederived from negative and overflow whenever either of them is recomputed. This lets a sequencer chain multi-byte arithmetic through the carry while increments, decrements and logic operations run in between.

Results leave through a one-entry registered output stage with a valid/ready handshake. A result that is not taken stays on the port unchanged. Status and result of an operation reflect every operation accepted before it, in acceptance order.

Top module: `flag_alu`

## Requirements
- R1: `in_ready` equals `!out_valid || out_ready`. An operation is accepted when `in_valid && in_ready`. Its result appears on the output stage in the next cycle. While `out_valid && !out_ready`, the output fields hold steady. Results come out one per accepted operation, in order. `in_op` codes run 0..26 in the order listed in the Ports table, and codes 27..31 write nothing and change no flag.
- R2: Add, add-with-carry, subtract and subtract-with-carry write the byte result and set Z, C, N, V and H. The with-carry forms add or subtract the incoming C. H is the carry out of bit 3 (add) or the borrow into bit 4 (subtract). C is the carry out of bit 7 or the borrow. V is signed overflow.
- R3: The two compare operations set Z, C, N, V and H exactly as the matching subtract would, including the incoming C for the carry form, and drive `out_we` low.
- R4: AND, OR and XOR write the result, update Z and N, clear V, and keep C and H.
- R5: Complement writes 0xFF minus A, sets C to 1 and clears V. Negate writes 0x00 minus A and sets Z, C, N, V and H like a subtraction from zero.
- R6: Increment and decrement write A±1 and update Z, N and V only. V is set when the result crosses 0x7F/0x80 in the signed direction. C and H are kept.
- R7: Shift left and shift right logical bring in 0. Rotate left and rotate right bring the old C into bit 0 or bit 7. Arithmetic shift right keeps bit 7. All five put the bit shifted out into C, update Z and N, and set V to N xor C.
- R8: Nibble swap writes the byte with its two halves exchanged and leaves all eight flags unchanged.
- R9: Every operation that recomputes N or V leaves S equal to N xor V.
- R10: Flag-set and flag-clear force the status bit chosen by `in_bit` to 1 or 0. Both write nothing. T-store copies bit `in_bit` of A into T and writes nothing. T-load writes A with bit `in_bit` replaced by T. Neither T operation changes any other flag.
- R11: Word add and word subtract combine the 16-bit A with the zero-extended immediate `in_b[5:0]` and write a 16-bit result. C is the carry or borrow out of bit 15. V is set for add when bit 15 goes from 0 to 1, and for subtract when it goes from 1 to 0. N is bit 15, Z marks a zero word, and S is N xor V. H is kept.
- R12: Branch-if-set and branch-if-clear drive `out_taken` high when status bit `in_bit` is 1 or 0 respectively. They write nothing and change no flag. Signed greater-or-equal is a branch-if-clear on S (bit 4), and unsigned lower is a branch-if-set on C (bit 0).
- R13: The status bits are, from bit 7 to bit 0: I, T, H, S, V, N, Z, C. After reset the status register is 0 and `out_valid` is low. Byte results are zero-extended in `out_result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted this cycle |
| in_op | input | 5 | Codes 0..26: ADD, ADC, SUB, SBC, CP, CPC, NEG, AND, OR, EOR, COM, INC, DEC, LSL, LSR, ROL, ROR, ASR, SWAP, FSET, FCLR, TSTORE, TLOAD, WADD, WSUB, BRSET, BRCLR |
| in_a | input | 16 | Operand A; the low byte for byte operations, the full pair for word operations |
| in_b | input | 8 | Operand B or immediate; word operations use bits 5..0 |
| in_bit | input | 3 | Bit index for flag, T and branch operations |
| out_valid | output | 1 | Result stage holds a result |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 16 | Result value |
| out_we | output | 1 | Result is to be written back |
| out_taken | output | 1 | Branch condition true |
| status | output | 8 | Current status register |

## Verification
On every cycle, the bound checker checks these flag rules at the acceptance edge:
- swap leaves the status untouched;
- increment and decrement keep C;
- logic operations keep C and H and clear V;
- complement sets C;
- compares never request a write;
- S stays equal to N xor V after every flag-computing operation.

It also checks that a stalled output holds steady. The exact values need the bench's scenarios, which check each against an independent model:
- half-carry and borrow positions;
- signed overflow at the 0x7F/0x80 boundary;
- carry injection into the with-carry and rotate forms;
- word wrap at 0xFFFF and 0x0000;
- branch outcomes after signed compares.

The same scenarios show that result order is kept under back-pressure.

// File: rtl/flag_alu_pkg.sv
`timescale 1ns/1ps
package flag_alu_pkg;
  localparam int NFLAG = 8;
  localparam int FL_C = 0;
  localparam int FL_Z = 1;
  localparam int FL_N = 2;
  localparam int FL_V = 3;
  localparam int FL_S = 4;
  localparam int FL_H = 5;
  localparam int FL_T = 6;
  localparam int FL_I = 7;

  typedef enum logic [4:0] {
    OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CP, OP_CPC, OP_NEG,
    OP_AND, OP_OR, OP_EOR, OP_COM, OP_INC, OP_DEC,
    OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR, OP_SWAP,
    OP_FSET, OP_FCLR, OP_TSTORE, OP_TLOAD, OP_WADD, OP_WSUB,
    OP_BRSET, OP_BRCLR
  } alu_op_e;
endpackage

// File: rtl/flag_alu_addsub.sv
`timescale 1ns/1ps
// Byte adder/subtractor with carry-in, giving carry, half-carry and overflow.
module flag_alu_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] r,
  output logic         c,
  output logic         h,
  output logic         v
);
  localparam int HB = W / 2;

  logic [W:0]  full;
  logic [HB:0] low;

  always_comb begin
    if (sub) begin
      full = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
      low  = {1'b0, a[HB-1:0]} - {1'b0, b[HB-1:0]} - {{HB{1'b0}}, cin};
    end else begin
      full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
      low  = {1'b0, a[HB-1:0]} + {1'b0, b[HB-1:0]} + {{HB{1'b0}}, cin};
    end
    r = full[W-1:0];
    c = full[W];
    h = low[HB];
    if (sub) v = (a[W-1] != b[W-1]) && (r[W-1] != a[W-1]);
    else     v = (a[W-1] == b[W-1]) && (r[W-1] != a[W-1]);
  end
endmodule

// File: rtl/flag_alu_word.sv
`timescale 1ns/1ps
// Register-pair add/subtract of a small zero-extended immediate.
module flag_alu_word #(
  parameter int W    = 16,
  parameter int IMMW = 6
) (
  input  logic [W-1:0]    a,
  input  logic [IMMW-1:0] imm,
  input  logic            sub,
  output logic [W-1:0]    r,
  output logic            c,
  output logic            v
);
  logic [W:0] full;
  logic [W:0] ext;

  always_comb begin
    ext  = {{(W+1-IMMW){1'b0}}, imm};
    full = sub ? ({1'b0, a} - ext) : ({1'b0, a} + ext);
    r    = full[W-1:0];
    c    = full[W];
    v    = sub ? (a[W-1] & ~r[W-1]) : (~a[W-1] & r[W-1]);
  end
endmodule

// File: rtl/flag_alu_cond.sv
`timescale 1ns/1ps
// Branch test: one selected status bit compared with the wanted sense.
module flag_alu_cond #(
  parameter int NF = 8,
  localparam int SW = $clog2(NF)
) (
  input  logic [NF-1:0] flags,
  input  logic [SW-1:0] sel,
  input  logic          sense,
  output logic          taken
);
  assign taken = (flags[sel] == sense);
endmodule

// File: rtl/flag_alu.sv
`timescale 1ns/1ps
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int DW   = 8,
  parameter int IMMW = 6,
  localparam int WW  = 2 * DW,
  localparam int BW  = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [4:0]    in_op,
  input  logic [WW-1:0] in_a,
  input  logic [DW-1:0] in_b,
  input  logic [BW-1:0] in_bit,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [WW-1:0] out_result,
  output logic          out_we,
  output logic          out_taken,
  output logic [NFLAG-1:0] status
);
  localparam int HB = DW / 2;

  alu_op_e op;
  assign op = alu_op_e'(in_op);

  logic [DW-1:0] a8;
  assign a8 = in_a[DW-1:0];

  // adder operand selection
  logic [DW-1:0] as_x, as_y, as_r;
  logic          as_cin, as_sub, as_c, as_h, as_v;

  always_comb begin
    as_x   = a8;
    as_y   = in_b;
    as_cin = 1'b0;
    as_sub = 1'b0;
    case (op)
      OP_ADC:        as_cin = status[FL_C];
      OP_SUB, OP_CP: as_sub = 1'b1;
      OP_SBC, OP_CPC: begin
        as_sub = 1'b1;
        as_cin = status[FL_C];
      end
      OP_NEG: begin
        as_x   = '0;
        as_y   = a8;
        as_sub = 1'b1;
      end
      OP_INC: as_y = {{(DW-1){1'b0}}, 1'b1};
      OP_DEC: begin
        as_y   = {{(DW-1){1'b0}}, 1'b1};
        as_sub = 1'b1;
      end
      default: ;
    endcase
  end

  flag_alu_addsub #(.W(DW)) u_addsub (
    .a(as_x), .b(as_y), .cin(as_cin), .sub(as_sub),
    .r(as_r), .c(as_c), .h(as_h), .v(as_v)
  );

  logic [WW-1:0] wd_r;
  logic          wd_c, wd_v;

  flag_alu_word #(.W(WW), .IMMW(IMMW)) u_word (
    .a(in_a), .imm(in_b[IMMW-1:0]), .sub(op == OP_WSUB),
    .r(wd_r), .c(wd_c), .v(wd_v)
  );

  logic cond_taken;

  flag_alu_cond #(.NF(NFLAG)) u_cond (
    .flags(status), .sel(in_bit), .sense(op == OP_BRSET), .taken(cond_taken)
  );

  // result and next-flag computation
  logic [DW-1:0]    r8;
  logic [WW-1:0]    res;
  logic [NFLAG-1:0] nxt;
  logic             we, taken, upd_nz, wide, shout;

  always_comb begin
    nxt    = status;
    r8     = '0;
    we     = 1'b0;
    taken  = 1'b0;
    upd_nz = 1'b0;
    wide   = 1'b0;
    shout  = 1'b0;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CP, OP_CPC, OP_NEG: begin
        r8        = as_r;
        we        = !(op == OP_CP || op == OP_CPC);
        nxt[FL_C] = as_c;
        nxt[FL_H] = as_h;
        nxt[FL_V] = as_v;
        upd_nz    = 1'b1;
      end
      OP_INC, OP_DEC: begin
        r8        = as_r;
        we        = 1'b1;
        nxt[FL_V] = as_v;
        upd_nz    = 1'b1;
      end
      OP_AND, OP_OR, OP_EOR: begin
        if (op == OP_AND)     r8 = a8 & in_b;
        else if (op == OP_OR) r8 = a8 | in_b;
        else                  r8 = a8 ^ in_b;
        we        = 1'b1;
        nxt[FL_V] = 1'b0;
        upd_nz    = 1'b1;
      end
      OP_COM: begin
        r8        = ~a8;
        we        = 1'b1;
        nxt[FL_C] = 1'b1;
        nxt[FL_V] = 1'b0;
        upd_nz    = 1'b1;
      end
      OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR: begin
        case (op)
          OP_LSL: begin r8 = {a8[DW-2:0], 1'b0};          shout = a8[DW-1]; end
          OP_ROL: begin r8 = {a8[DW-2:0], status[FL_C]};  shout = a8[DW-1]; end
          OP_LSR: begin r8 = {1'b0, a8[DW-1:1]};          shout = a8[0];    end
          OP_ROR: begin r8 = {status[FL_C], a8[DW-1:1]};  shout = a8[0];    end
          default: begin r8 = {a8[DW-1], a8[DW-1:1]};     shout = a8[0];    end
        endcase
        we        = 1'b1;
        nxt[FL_C] = shout;
        nxt[FL_V] = r8[DW-1] ^ shout;
        upd_nz    = 1'b1;
      end
      OP_SWAP: begin
        r8 = {a8[HB-1:0], a8[DW-1:HB]};
        we = 1'b1;
      end
      OP_FSET:   nxt[in_bit] = 1'b1;
      OP_FCLR:   nxt[in_bit] = 1'b0;
      OP_TSTORE: nxt[FL_T]   = a8[in_bit];
      OP_TLOAD: begin
        r8         = a8;
        r8[in_bit] = status[FL_T];
        we         = 1'b1;
      end
      OP_WADD, OP_WSUB: begin
        wide      = 1'b1;
        we        = 1'b1;
        nxt[FL_C] = wd_c;
        nxt[FL_V] = wd_v;
        nxt[FL_N] = wd_r[WW-1];
        nxt[FL_Z] = (wd_r == '0);
      end
      OP_BRSET, OP_BRCLR: taken = cond_taken;
      default: ;
    endcase
    if (upd_nz) begin
      nxt[FL_N] = r8[DW-1];
      nxt[FL_Z] = (r8 == '0);
    end
    if (upd_nz || wide) nxt[FL_S] = nxt[FL_N] ^ nxt[FL_V];
    res = wide ? wd_r : {{DW{1'b0}}, r8};
  end

  // one-entry output stage
  logic accept;
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status     <= '0;
      out_valid  <= 1'b0;
      out_result <= '0;
      out_we     <= 1'b0;
      out_taken  <= 1'b0;
    end else if (accept) begin
      status     <= nxt;
      out_valid  <= 1'b1;
      out_result <= res;
      out_we     <= we;
      out_taken  <= taken;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/flag_alu_sva.sv
`timescale 1ns/1ps
module flag_alu_sva
  import flag_alu_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [4:0]  in_op,
  input logic        out_valid,
  input logic        out_ready,
  input logic [15:0] out_result,
  input logic        out_we,
  input logic [7:0]  status
);
  logic acc;
  assign acc = in_valid && in_ready;

  logic flag_op;
  assign flag_op = (in_op <= OP_ASR) || (in_op == OP_WADD) || (in_op == OP_WSUB);

  AST_OUTPUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_we)); // R1

  AST_COMPARE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (in_op == OP_CP || in_op == OP_CPC) |=> !out_we); // R3

  AST_LOGIC_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (in_op == OP_AND || in_op == OP_OR || in_op == OP_EOR) |=>
      status[FL_C] == $past(status[FL_C]) && status[FL_H] == $past(status[FL_H]) && !status[FL_V]); // R4

  AST_COM_SETS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op == OP_COM |=> status[FL_C] && !status[FL_V]); // R5

  AST_INCDEC_KEEPS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (in_op == OP_INC || in_op == OP_DEC) |=>
      status[FL_C] == $past(status[FL_C]) && status[FL_H] == $past(status[FL_H])); // R6

  AST_SWAP_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op == OP_SWAP |=> status == $past(status)); // R8

  AST_SIGN_CONSISTENT: assert property (@(posedge clk) disable iff (!rst_n)
    acc && flag_op |=> status[FL_S] == (status[FL_N] ^ status[FL_V])); // R9
endmodule

bind flag_alu flag_alu_sva u_sva (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .out_valid(out_valid), .out_ready(out_ready),
  .out_result(out_result), .out_we(out_we), .status(status)
);

// File: tb/flag_alu_tb.sv
`timescale 1ns/1ps
module flag_alu_tb;
  import flag_alu_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [4:0]  in_op = '0;
  logic [15:0] in_a = '0;
  logic [7:0]  in_b = '0;
  logic [2:0]  in_bit = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_result;
  logic        out_we, out_taken;
  logic [7:0]  status;

  always #10 clk = ~clk;

  flag_alu u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_bit(in_bit),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_we(out_we), .out_taken(out_taken), .status(status)
  );

  typedef struct {
    logic [15:0] r;
    logic        we;
    logic        tk;
    logic [7:0]  st;
    string       tag;
  } item_t;

  item_t q[$];
  int n_chk = 0, n_fail = 0, n_sent = 0, n_got = 0;
  logic [7:0] mst = '0;
  logic stall_en = 1'b0;
  logic [1:0] cyc = '0;
  bit done = 0;

  always @(posedge clk) begin
    cyc <= cyc + 2'd1;
    out_ready <= !stall_en || (cyc == 2'b11);
  end

  function automatic int sgn(input logic [7:0] x);
    return x[7] ? int'(x) - 256 : int'(x);
  endfunction

  // Independent model of the requirements; st is the shadow status.
  function automatic void model(input alu_op_e op, input logic [15:0] a, input logic [7:0] b,
                                input logic [2:0] bi, inout logic [7:0] st,
                                output logic [15:0] r, output logic we, output logic tk);
    logic [7:0] a8, x, y, o;
    int s, lo, sv, ci;
    logic nz, sh;
    a8 = a[7:0]; r = '0; we = 1'b1; tk = 1'b0; nz = 1'b0;
    case (op)
      OP_ADD, OP_ADC: begin
        ci = (op == OP_ADC) ? int'(st[0]) : 0;
        s  = int'(a8) + int'(b) + ci;
        lo = int'(a8 & 8'h0F) + int'(b & 8'h0F) + ci;
        sv = sgn(a8) + sgn(b) + ci;
        o = 8'(s); st[0] = s > 255; st[5] = lo > 15; st[3] = (sv > 127) || (sv < -128); nz = 1;
      end
      OP_SUB, OP_SBC, OP_CP, OP_CPC, OP_NEG: begin
        x  = (op == OP_NEG) ? 8'h00 : a8;
        y  = (op == OP_NEG) ? a8 : b;
        ci = (op == OP_SBC || op == OP_CPC) ? int'(st[0]) : 0;
        s  = int'(x) - int'(y) - ci;
        lo = int'(x & 8'h0F) - int'(y & 8'h0F) - ci;
        sv = sgn(x) - sgn(y) - ci;
        o = 8'(s); st[0] = s < 0; st[5] = lo < 0; st[3] = (sv > 127) || (sv < -128); nz = 1;
        we = !(op == OP_CP || op == OP_CPC);
      end
      OP_AND, OP_OR, OP_EOR: begin
        o = (op == OP_AND) ? (a8 & b) : (op == OP_OR) ? (a8 | b) : (a8 ^ b);
        st[3] = 0; nz = 1;
      end
      OP_COM: begin o = 8'hFF - a8; st[0] = 1; st[3] = 0; nz = 1; end
      OP_INC: begin o = a8 + 8'd1; st[3] = (a8 == 8'h7F); nz = 1; end
      OP_DEC: begin o = a8 - 8'd1; st[3] = (a8 == 8'h80); nz = 1; end
      OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR: begin
        if (op == OP_LSL || op == OP_ROL) begin
          sh = a8[7]; o = (a8 << 1) | ((op == OP_ROL) ? {7'd0, st[0]} : 8'd0);
        end else begin
          sh = a8[0]; o = a8 >> 1;
          if (op == OP_ROR) o[7] = st[0];
          if (op == OP_ASR) o[7] = a8[7];
        end
        st[0] = sh; st[3] = o[7] ^ sh; nz = 1;
      end
      OP_SWAP: o = {a8[3:0], a8[7:4]};
      OP_FSET: begin st[bi] = 1; we = 0; end
      OP_FCLR: begin st[bi] = 0; we = 0; end
      OP_TSTORE: begin st[6] = a8[bi]; we = 0; end
      OP_TLOAD: begin o = a8; o[bi] = st[6]; end
      OP_WADD, OP_WSUB: begin
        s = (op == OP_WADD) ? int'(a) + int'(b[5:0]) : int'(a) - int'(b[5:0]);
        r = 16'(s);
        st[0] = (op == OP_WADD) ? (s > 65535) : (s < 0);
        st[3] = (op == OP_WADD) ? (!a[15] && r[15]) : (a[15] && !r[15]);
        st[2] = r[15]; st[1] = (r == 0); st[4] = st[2] ^ st[3];
      end
      OP_BRSET: begin tk = st[bi]; we = 0; end
      OP_BRCLR: begin tk = !st[bi]; we = 0; end
      default: we = 0;
    endcase
    if (op <= OP_TLOAD && we) r = {8'h00, o};
    if (nz) begin st[2] = o[7]; st[1] = (o == 0); st[4] = st[2] ^ st[3]; end
  endfunction

  task automatic send(input alu_op_e op, input logic [15:0] a, input logic [7:0] b,
                      input int bi, input string tag);
    item_t it;
    logic [7:0] st;
    st = mst;
    model(op, a, b, 3'(bi), st, it.r, it.we, it.tk);
    mst = st; it.st = st; it.tag = tag;
    q.push_back(it);
    n_sent++;
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b; in_bit = 3'(bi);
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      item_t e;
      n_got++;
      if (q.size() == 0) check(0, "R1", "unexpected result", 32'(out_result), 0);
      else begin
        e = q.pop_front();
        check((out_we == e.we) && (out_taken == e.tk) && (status == e.st) &&
              (!e.we || out_result == e.r), e.tag, "res/we/tk/status",
              {out_result, 5'd0, out_we, out_taken, 1'b0, status},
              {e.r, 5'd0, e.we, e.tk, 1'b0, e.st});
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      check(0, "R1", "watchdog expired", 0, 1);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(status == 8'h00, "R13", "reset status", 32'(status), 0);
    check(!out_valid, "R13", "reset out_valid", 32'(out_valid), 0);
    check(in_ready, "R1", "ready after reset", 32'(in_ready), 1);
    rst_n = 1'b1;

    // R2 add and subtract
    send(OP_ADD, 16'h000F, 8'h01, 0, "R2");
    send(OP_ADD, 16'h0080, 8'h80, 0, "R2");
    send(OP_ADC, 16'h007F, 8'h00, 0, "R2");
    send(OP_SUB, 16'h0010, 8'h01, 0, "R2");
    send(OP_SUB, 16'h0000, 8'h01, 0, "R2");
    send(OP_SBC, 16'h0005, 8'h02, 0, "R2");
    // R3 compares
    send(OP_CP,  16'h0042, 8'h42, 0, "R3");
    send(OP_FSET, 16'h0000, 8'h00, 0, "R10");
    send(OP_CPC, 16'h0042, 8'h41, 0, "R3");
    // R12 signed compare then branch tests
    send(OP_CP,  16'h0080, 8'h01, 0, "R3");
    send(OP_BRCLR, 16'h0000, 8'h00, 4, "R12");
    send(OP_BRSET, 16'h0000, 8'h00, 4, "R12");
    send(OP_CP,  16'h0001, 8'h02, 0, "R3");
    send(OP_BRSET, 16'h0000, 8'h00, 0, "R12");
    // R4 logic with C and H set beforehand
    send(OP_FSET, 16'h0000, 8'h00, 5, "R10");
    send(OP_AND, 16'h00F0, 8'h0F, 0, "R4");
    send(OP_OR,  16'h0080, 8'h01, 0, "R4");
    send(OP_EOR, 16'h00AA, 8'hFF, 0, "R4");
    // R5
    send(OP_COM, 16'h00FF, 8'h00, 0, "R5");
    send(OP_NEG, 16'h0080, 8'h00, 0, "R5");
    send(OP_NEG, 16'h0000, 8'h00, 0, "R5");
    send(OP_NEG, 16'h0001, 8'h00, 0, "R5");
    // R6 with C set
    send(OP_FSET, 16'h0000, 8'h00, 0, "R10");
    send(OP_INC, 16'h007F, 8'h00, 0, "R6");
    send(OP_INC, 16'h00FF, 8'h00, 0, "R6");
    send(OP_DEC, 16'h0080, 8'h00, 0, "R6");
    send(OP_DEC, 16'h0000, 8'h00, 0, "R6");
    // R7 with back-pressure on the output
    stall_en = 1'b1;
    send(OP_LSL, 16'h0081, 8'h00, 0, "R7");
    send(OP_ROL, 16'h0040, 8'h00, 0, "R7");
    send(OP_LSR, 16'h0001, 8'h00, 0, "R7");
    send(OP_FSET, 16'h0000, 8'h00, 0, "R10");
    send(OP_ROR, 16'h0002, 8'h00, 0, "R7");
    send(OP_ASR, 16'h0081, 8'h00, 0, "R7");
    send(OP_SWAP, 16'h003C, 8'h00, 0, "R8");
    stall_en = 1'b0;
    // R10 T bit and flags
    send(OP_TSTORE, 16'h0008, 8'h00, 3, "R10");
    send(OP_TLOAD, 16'h0000, 8'h00, 7, "R10");
    send(OP_FCLR, 16'h0000, 8'h00, 6, "R10");
    send(OP_TLOAD, 16'h00FF, 8'h00, 0, "R10");
    send(OP_FSET, 16'h0000, 8'h00, 7, "R10");
    send(OP_SWAP, 16'h00A5, 8'h00, 0, "R8");
    // R11 word ops
    send(OP_WADD, 16'hFFFF, 8'h01, 0, "R11");
    send(OP_WADD, 16'h7FFF, 8'hC1, 0, "R11");
    send(OP_WSUB, 16'h0000, 8'h01, 0, "R11");
    send(OP_WSUB, 16'h8000, 8'h3F, 0, "R11");
    send(OP_WSUB, 16'h0010, 8'h10, 0, "R11");
    // R9 S after overflowing add
    send(OP_ADD, 16'h0040, 8'h40, 0, "R9");
    // R1 unused code changes nothing
    @(negedge clk);
    in_valid = 1'b1; in_op = 5'd30; #1;
    while (!in_ready) begin @(negedge clk); #1; end
    begin item_t it; it.r = 0; it.we = 0; it.tk = 0; it.st = mst; it.tag = "R1";
      q.push_back(it); n_sent++; end
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    while (q.size() != 0) @(negedge clk);
    check(n_got == n_sent, "R1", "result count", 32'(n_got), 32'(n_sent));
    done = 1;
    finish_run();
  end
endmodule